// File: doc/BRIEF.md
# Bulk Packet Splitter and Combiner

This block is the length-control core of a bulk endpoint whose FIFO can hold more data than one USB packet carries. On the transmit side, software posts the length of a large buffer. The block then produces a sequence of packet descriptors for the link layer:

- every descriptor carries the configured payload size, except the final one, which carries what remains;
- a zero-length packet is appended only when software asks for one.

On the receive side, the link layer reports the length of each incoming packet. The block adds these lengths up and tells software that one merged buffer is ready. It does so when a short packet ends the transfer, or when the buffer has reached its limit of multiplier times payload.

Splitting and combining are switched on separately. With either one off, that direction behaves as a plain one-packet buffer: a posted buffer leaves as one packet, and every received packet is reported on its own.

The packet size is set by a three-bit payload code, a multiplier and a speed bit. An illegal combination raises a configuration error, and the endpoint stays inert for as long as the error is present.

Top module: `bulk_split_combine`

## Requirements
- R1: After reset, `pkt_valid` and `rx_buf_valid` are 0 and `tx_ready` is 1.
- R2: The payload code maps to a payload size as follows: 0 gives 8 bytes, 1 gives 16, 2 gives 32, 3 gives 64 and 4 gives 512.
- R3: `cfg_err` is 1 in any of these cases: the payload code is above 4; the code is 4 while `high_speed` is 0; the multiplier is 0; the multiplier is above 32. Otherwise `cfg_err` is 0.
- R4: While `cfg_err` is 1, a `tx_start` produces no packet, and a received packet produces no `rx_buf_valid` one cycle later.
- R5: With `split_en` = 1, `tx_start` while `tx_ready` = 1 makes `pkt_valid` rise in the next cycle. Each packet is min(remaining, payload) bytes. `pkt_last` marks the final packet, and `pkt_valid` falls after the final packet is accepted.
- R6: When the final data packet of a buffer is exactly a full payload, a zero-length packet follows only if `tx_zlp` was 1 at the start. A buffer of length 0 gives a single zero-length packet with `pkt_last` = 1.
- R7: With `split_en` = 0, a buffer leaves as one packet carrying its whole length. A zero-length packet follows it when `tx_zlp` = 1 and the length equals the payload.
- R8: While `pkt_valid` = 1 and `pkt_ready` = 0, the packet length and the last flag hold. While a buffer is in progress, `tx_ready` = 0 and `tx_start` is ignored.
- R9: With `comb_en` = 1, received lengths accumulate. A packet shorter than the payload ends the buffer. One cycle after that packet, `rx_buf_valid` pulses with `rx_buf_len` equal to the total.
- R10: With `comb_en` = 1, the buffer is also reported once the total reaches or exceeds multiplier × payload.
- R11: With `comb_en` = 0, every received packet is reported alone, one cycle later, with its own length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| split_en | input | 1 | Split transmit buffers into payload-sized packets |
| comb_en | input | 1 | Merge received packets into one buffer |
| pay_code | input | 3 | Payload size code (0..4) |
| mult | input | 6 | Maximum packets per buffer (1..32) |
| high_speed | input | 1 | High-speed operation; permits code 4 |
| cfg_err | output | 1 | Illegal configuration; endpoint inert |
| tx_start | input | 1 | Post a transmit buffer |
| tx_len | input | 16 | Transmit buffer length in bytes |
| tx_zlp | input | 1 | Request a trailing zero-length packet |
| tx_ready | output | 1 | Ready to accept a buffer |
| pkt_valid | output | 1 | Packet descriptor valid |
| pkt_ready | input | 1 | Link layer takes the descriptor |
| pkt_len | output | 16 | Packet length in bytes |
| pkt_last | output | 1 | Final packet of the buffer |
| rx_pkt_valid | input | 1 | A packet was received |
| rx_pkt_len | input | 10 | Received packet length in bytes |
| rx_buf_valid | output | 1 | Merged buffer ready (one-cycle pulse) |
| rx_buf_len | output | 16 | Merged buffer length in bytes |

## Verification
The hardest case to reach is the one where the receive total lands exactly on multiplier × payload with no short packet, and the transmit case where a buffer is an exact payload multiple with the zero-length request set. Random configurations use mostly small multipliers, and the received packets are mostly full-size, so the byte limit is reached often. Directed transmit buffers at exact multiples are posted both with and without the zero-length flag. Random stalls on `pkt_ready` exercise the holding rule, and each receive run ends with a flushing zero-length packet so that the model and the block start every configuration empty.

// File: rtl/bsc_pkg.sv
`timescale 1ns/1ps
// Shared widths and payload code values for the bulk splitter/combiner.
package bsc_pkg;
    localparam int PAY_W  = 10;   // holds the largest payload, 512
    localparam int CODE_W = 3;
    typedef enum logic [CODE_W-1:0] {
        PAY8   = 3'd0,
        PAY16  = 3'd1,
        PAY32  = 3'd2,
        PAY64  = 3'd3,
        PAY512 = 3'd4
    } pay_code_e;
endpackage

// File: rtl/bsc_cfg_decode.sv
`timescale 1ns/1ps
// Decodes payload code and multiplier into payload bytes and buffer limit.
// Assumes configuration is stable while a transfer is in progress.
module bsc_cfg_decode
    import bsc_pkg::*;
#(
    parameter int MULT_W   = 6,
    parameter int MAX_MULT = 32,
    parameter int LEN_W    = 16
) (
    input  logic [CODE_W-1:0] pay_code,
    input  logic [MULT_W-1:0] mult,
    input  logic              high_speed,
    output logic [PAY_W-1:0]  pay_bytes,
    output logic [LEN_W-1:0]  buf_limit,
    output logic              cfg_err
);
    logic code_bad;

    // Map code to payload size and flag codes that are illegal
    always_comb begin
        code_bad = 1'b0;
        case (pay_code_e'(pay_code))
            PAY8:    pay_bytes = PAY_W'(8);
            PAY16:   pay_bytes = PAY_W'(16);
            PAY32:   pay_bytes = PAY_W'(32);
            PAY64:   pay_bytes = PAY_W'(64);
            PAY512: begin
                pay_bytes = PAY_W'(512);
                code_bad  = !high_speed;
            end
            default: begin
                pay_bytes = PAY_W'(8);
                code_bad  = 1'b1;
            end
        endcase
    end

    // Combine code and multiplier checks, and form the buffer byte limit
    always_comb begin
        cfg_err   = code_bad || (mult == '0) || (int'(mult) > MAX_MULT);
        buf_limit = LEN_W'(mult) * LEN_W'(pay_bytes);
    end
endmodule

// File: rtl/bsc_tx_split.sv
`timescale 1ns/1ps
// Cuts a posted transmit buffer into payload-sized packet descriptors.
// Assumes configuration is held stable while a buffer is in progress.
module bsc_tx_split
    import bsc_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             split_en,
    input  logic             cfg_err,
    input  logic [PAY_W-1:0] pay_bytes,
    input  logic             tx_start,
    input  logic [LEN_W-1:0] tx_len,
    input  logic             tx_zlp,
    output logic             tx_ready,
    output logic             pkt_valid,
    input  logic             pkt_ready,
    output logic [LEN_W-1:0] pkt_len,
    output logic             pkt_last
);
    logic             busy;
    logic             zlp_q;
    logic [LEN_W-1:0] rem;
    logic [LEN_W-1:0] rem_next;
    logic [LEN_W-1:0] pay_l;
    logic             full_pkt;

    // Size the current packet and decide whether it ends the buffer
    always_comb begin
        pay_l    = LEN_W'(pay_bytes);
        pkt_len  = (split_en && rem > pay_l) ? pay_l : rem;
        rem_next = rem - pkt_len;
        full_pkt = (pkt_len == pay_l) && (pkt_len != '0);
        pkt_last = (rem_next == '0) && !(zlp_q && full_pkt);
        pkt_valid = busy;
        tx_ready  = !busy;
    end

    // Load a new buffer when idle, step through packets on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            zlp_q <= 1'b0;
            rem   <= '0;
        end else if (!busy) begin
            if (tx_start && !cfg_err) begin
                busy  <= 1'b1;
                rem   <= tx_len;
                zlp_q <= tx_zlp;
            end
        end else if (pkt_ready) begin
            if (pkt_last) begin
                busy <= 1'b0;
            end
            rem <= rem_next;
        end
    end
endmodule

// File: rtl/bsc_rx_combine.sv
`timescale 1ns/1ps
// Merges received packet lengths into one buffer length.
// Reports on a short packet or at the byte limit; assumes stable config.
module bsc_rx_combine
    import bsc_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             comb_en,
    input  logic             cfg_err,
    input  logic [PAY_W-1:0] pay_bytes,
    input  logic [LEN_W-1:0] buf_limit,
    input  logic             rx_pkt_valid,
    input  logic [PAY_W-1:0] rx_pkt_len,
    output logic             rx_buf_valid,
    output logic [LEN_W-1:0] rx_buf_len
);
    logic [LEN_W-1:0] acc;
    logic [LEN_W-1:0] sum;
    logic             done;

    // Form the running total and the end-of-buffer condition
    always_comb begin
        sum  = acc + LEN_W'(rx_pkt_len);
        done = !comb_en || (rx_pkt_len < pay_bytes) || (sum >= buf_limit);
    end

    // Accumulate lengths and issue a one-cycle ready pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc          <= '0;
            rx_buf_valid <= 1'b0;
            rx_buf_len   <= '0;
        end else begin
            rx_buf_valid <= 1'b0;
            if (rx_pkt_valid && !cfg_err) begin
                if (done) begin
                    rx_buf_valid <= 1'b1;
                    rx_buf_len   <= comb_en ? sum : LEN_W'(rx_pkt_len);
                    acc          <= '0;
                end else begin
                    acc <= sum;
                end
            end
        end
    end
endmodule

// File: rtl/bulk_split_combine.sv
`timescale 1ns/1ps
// Bulk endpoint length control: splits transmit buffers into packets and
// combines received packets into buffers. Configuration must not change
// while a transmit buffer or a partial receive buffer is outstanding.
module bulk_split_combine
    import bsc_pkg::*;
#(
    parameter int MULT_W   = 6,
    parameter int MAX_MULT = 32,
    parameter int LEN_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              split_en,
    input  logic              comb_en,
    input  logic [CODE_W-1:0] pay_code,
    input  logic [MULT_W-1:0] mult,
    input  logic              high_speed,
    output logic              cfg_err,
    input  logic              tx_start,
    input  logic [LEN_W-1:0]  tx_len,
    input  logic              tx_zlp,
    output logic              tx_ready,
    output logic              pkt_valid,
    input  logic              pkt_ready,
    output logic [LEN_W-1:0]  pkt_len,
    output logic              pkt_last,
    input  logic              rx_pkt_valid,
    input  logic [PAY_W-1:0]  rx_pkt_len,
    output logic              rx_buf_valid,
    output logic [LEN_W-1:0]  rx_buf_len
);
    logic [PAY_W-1:0] pay_bytes;
    logic [LEN_W-1:0] buf_limit;

    bsc_cfg_decode #(.MULT_W(MULT_W), .MAX_MULT(MAX_MULT), .LEN_W(LEN_W)) u_dec (
        .pay_code  (pay_code),
        .mult      (mult),
        .high_speed(high_speed),
        .pay_bytes (pay_bytes),
        .buf_limit (buf_limit),
        .cfg_err   (cfg_err)
    );

    bsc_tx_split #(.LEN_W(LEN_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .split_en (split_en),
        .cfg_err  (cfg_err),
        .pay_bytes(pay_bytes),
        .tx_start (tx_start),
        .tx_len   (tx_len),
        .tx_zlp   (tx_zlp),
        .tx_ready (tx_ready),
        .pkt_valid(pkt_valid),
        .pkt_ready(pkt_ready),
        .pkt_len  (pkt_len),
        .pkt_last (pkt_last)
    );

    bsc_rx_combine #(.LEN_W(LEN_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .comb_en     (comb_en),
        .cfg_err     (cfg_err),
        .pay_bytes   (pay_bytes),
        .buf_limit   (buf_limit),
        .rx_pkt_valid(rx_pkt_valid),
        .rx_pkt_len  (rx_pkt_len),
        .rx_buf_valid(rx_buf_valid),
        .rx_buf_len  (rx_buf_len)
    );
endmodule

// File: rtl/bulk_split_combine_chk.sv
`timescale 1ns/1ps
// Protocol checks for bulk_split_combine, attached by bind below.
module bulk_split_combine_chk
    import bsc_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             split_en,
    input logic             cfg_err,
    input logic             tx_start,
    input logic             tx_ready,
    input logic             pkt_valid,
    input logic             pkt_ready,
    input logic [LEN_W-1:0] pkt_len,
    input logic             pkt_last,
    input logic             rx_buf_valid,
    input logic [PAY_W-1:0] pay_bytes
);
    // R5: an accepted start yields a packet next cycle
    p_start_emits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start && tx_ready && !cfg_err |=> pkt_valid);

    // R5: split packets never exceed the payload
    p_pkt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && split_en |-> pkt_len <= LEN_W'(pay_bytes));

    // R8: a stalled descriptor holds
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_len) && $stable(pkt_last));

    // R6: accepting the last packet ends the buffer
    p_last_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && pkt_ready && pkt_last |=> !pkt_valid);

    // R4: an illegal configuration reports no buffer
    p_err_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> !rx_buf_valid);
endmodule

bind bulk_split_combine bulk_split_combine_chk #(.LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .split_en    (split_en),
    .cfg_err     (cfg_err),
    .tx_start    (tx_start),
    .tx_ready    (tx_ready),
    .pkt_valid   (pkt_valid),
    .pkt_ready   (pkt_ready),
    .pkt_len     (pkt_len),
    .pkt_last    (pkt_last),
    .rx_buf_valid(rx_buf_valid),
    .pay_bytes   (pay_bytes)
);

// File: tb/bulk_split_combine_tb_top.sv
`timescale 1ns/1ps
// Bench for bulk_split_combine: random configurations plus directed corners.
module bulk_split_combine_tb_top;
    localparam int LEN_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic split_en = 1'b1, comb_en = 1'b1, high_speed = 1'b1;
    logic [2:0] pay_code = 3'd0;
    logic [5:0] mult = 6'd4;
    logic cfg_err, tx_ready, pkt_valid, pkt_last, rx_buf_valid;
    logic tx_start = 1'b0, tx_zlp = 1'b0, pkt_ready = 1'b0, rx_pkt_valid = 1'b0;
    logic [LEN_W-1:0] tx_len = '0;
    logic [LEN_W-1:0] pkt_len, rx_buf_len;
    logic [9:0] rx_pkt_len = '0;

    int checks = 0;
    int fails = 0;
    int acc_m = 0;
    int unused_seed;

    always #2.5 clk = ~clk;

    bulk_split_combine dut_i (
        .clk(clk), .rst_n(rst_n), .split_en(split_en), .comb_en(comb_en),
        .pay_code(pay_code), .mult(mult), .high_speed(high_speed), .cfg_err(cfg_err),
        .tx_start(tx_start), .tx_len(tx_len), .tx_zlp(tx_zlp), .tx_ready(tx_ready),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_len(pkt_len), .pkt_last(pkt_last),
        .rx_pkt_valid(rx_pkt_valid), .rx_pkt_len(rx_pkt_len),
        .rx_buf_valid(rx_buf_valid), .rx_buf_len(rx_buf_len)
    );

    function automatic int pay_of(input int code);
        case (code)
            0: return 8;
            1: return 16;
            2: return 32;
            3: return 64;
            default: return 512;
        endcase
    endfunction

    function automatic bit err_of(input int code, input int m, input bit hs);
        return (code > 4) || (code == 4 && !hs) || (m == 0) || (m > 32);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Post a buffer and follow every packet with random stalls (R5-R8)
    task automatic run_tx(input int len, input bit zlp, input bit poke);
        int pay, rem, cur;
        bit last, done;
        pay = pay_of(int'(pay_code));
        rem = len;
        @(negedge clk);
        tx_start = 1'b1; tx_len = LEN_W'(len); tx_zlp = zlp;
        @(negedge clk);
        tx_start = 1'b0;
        check(pkt_valid == 1'b1, "R5 valid after start", int'(pkt_valid), 1);
        check(tx_ready == 1'b0, "R8 busy", int'(tx_ready), 0);
        done = 1'b0;
        while (!done) begin
            cur  = (split_en && rem > pay) ? pay : rem;
            last = (rem - cur == 0) && !(zlp && cur == pay && cur != 0);
            pkt_ready = ($urandom % 3) != 0;
            if (poke) begin
                tx_start = 1'b1; tx_len = LEN_W'(5);  // R8 ignored while busy
            end
            check(int'(pkt_len) == cur, split_en ? "R5 length" : "R7 length", int'(pkt_len), cur);
            check(pkt_last == last, "R6 last flag", int'(pkt_last), int'(last));
            if (pkt_ready) begin
                rem  = rem - cur;
                done = last;
            end
            @(negedge clk);
            tx_start = 1'b0;
        end
        pkt_ready = 1'b0;
        check(pkt_valid == 1'b0, "R6 end of buffer", int'(pkt_valid), 0);
        check(tx_ready == 1'b1, "R8 ready again", int'(tx_ready), 1);
    endtask

    // Send one received packet and compare the report against the model (R9-R11)
    task automatic rx_send(input int len);
        int pay, lim, sum;
        bit exp_v;
        int exp_l;
        pay = pay_of(int'(pay_code));
        lim = int'(mult) * pay;
        sum = acc_m + len;
        exp_v = 1'b1;
        exp_l = comb_en ? sum : len;
        if (comb_en && len >= pay && sum < lim) begin
            exp_v = 1'b0;
            acc_m = sum;
        end else begin
            acc_m = 0;
        end
        @(negedge clk);
        rx_pkt_valid = 1'b1; rx_pkt_len = 10'(len);
        @(negedge clk);
        rx_pkt_valid = 1'b0;
        check(rx_buf_valid == exp_v, comb_en ? "R9 R10 ready pulse" : "R11 ready pulse",
              int'(rx_buf_valid), int'(exp_v));
        if (exp_v)
            check(int'(rx_buf_len) == exp_l, comb_en ? "R9 R10 length" : "R11 length",
                  int'(rx_buf_len), exp_l);
    endtask

    task automatic set_cfg(input int code, input int m, input bit hs, input bit se, input bit ce);
        @(negedge clk);
        pay_code = 3'(code); mult = 6'(m); high_speed = hs; split_en = se; comb_en = ce;
        #0.1;
        check(cfg_err == err_of(code, m, hs), "R3 config error", int'(cfg_err),
              int'(err_of(code, m, hs)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        unused_seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(pkt_valid == 1'b0, "R1 pkt_valid", int'(pkt_valid), 0);
        check(rx_buf_valid == 1'b0, "R1 rx_buf_valid", int'(rx_buf_valid), 0);
        check(tx_ready == 1'b1, "R1 tx_ready", int'(tx_ready), 1);

        // R2 payload codes through the first split packet
        for (int c = 0; c < 5; c++) begin
            set_cfg(c, 8, 1'b1, 1'b1, 1'b1);
            run_tx(600, 1'b0, 1'b0);
        end

        // R3 / R4 illegal configurations keep the endpoint inert
        for (int k = 0; k < 4; k++) begin
            case (k)
                0: set_cfg(4, 4, 1'b0, 1'b1, 1'b1);
                1: set_cfg(1, 0, 1'b1, 1'b1, 1'b1);
                2: set_cfg(1, 33, 1'b1, 1'b1, 1'b1);
                default: set_cfg(6, 4, 1'b1, 1'b1, 1'b1);
            endcase
            @(negedge clk);
            tx_start = 1'b1; tx_len = LEN_W'(20);
            @(negedge clk);
            tx_start = 1'b0;
            check(pkt_valid == 1'b0, "R4 start ignored", int'(pkt_valid), 0);
            rx_pkt_valid = 1'b1; rx_pkt_len = 10'd3;
            @(negedge clk);
            rx_pkt_valid = 1'b0;
            check(rx_buf_valid == 1'b0, "R4 packet dropped", int'(rx_buf_valid), 0);
        end

        // R6 / R7 directed corners: exact multiples, zero length, busy poke
        set_cfg(1, 4, 1'b0, 1'b1, 1'b1);
        run_tx(48, 1'b0, 1'b0);
        run_tx(48, 1'b1, 1'b0);
        run_tx(0, 1'b0, 1'b0);
        run_tx(0, 1'b1, 1'b0);
        run_tx(37, 1'b0, 1'b1);
        set_cfg(1, 4, 1'b0, 1'b0, 1'b0);
        run_tx(16, 1'b1, 1'b0);
        run_tx(50, 1'b1, 1'b0);

        // R10 exact limit and R9 short ending, directed
        set_cfg(0, 3, 1'b0, 1'b1, 1'b1);
        acc_m = 0;
        rx_send(8); rx_send(8); rx_send(8);
        rx_send(8); rx_send(5);
        rx_send(0);

        // Random configurations
        for (int t = 0; t < 120; t++) begin
            int code, m, pay, lim, npk;
            code = $urandom % 5;
            m    = 1 + (($urandom % 4 == 0) ? $urandom % 32 : $urandom % 6);
            set_cfg(code, m, (code == 4) ? 1'b1 : 1'(($urandom % 2)),
                    1'(($urandom % 4) != 0), 1'(($urandom % 4) != 0));
            pay = pay_of(code);
            lim = m * pay;
            for (int b = 0; b < 3; b++) begin
                int len;
                len = ($urandom % 3 == 0) ? pay * (1 + $urandom % m) : $urandom % (lim + 1);
                run_tx(len, 1'(($urandom % 2)), 1'b0);
            end
            acc_m = 0;
            npk = 2 + $urandom % (m + 3);
            for (int p = 0; p < npk; p++)
                rx_send(($urandom % 4 == 0) ? $urandom % pay : pay);
            rx_send(0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule